// File: doc/BRIEF.md
# Descriptor-chained DMA channel engine

This block is one memory-to-memory DMA channel that takes its work from a linked list of descriptors in system memory. Each descriptor is eight 32-bit words at a 32-byte-aligned address. The words are a command word, a count word, a source address, a destination address, a status slot at word 6, a next-pointer at word 7, and two words the engine reads and discards. Software writes the address of the first descriptor into a pointer register, sets the enable bit, and writes any value to the doorbell register.

The channel then fetches descriptors one after another. For each valid descriptor it copies the programmed number of bytes, one 32-bit word at a time. It may write a completion word back into the descriptor's status slot, and it may clear the descriptor's own valid bit. It then raises an interrupt-pending flag and follows the next pointer. The channel halts when it meets a descriptor whose valid bit is clear. It also halts at a descriptor boundary once software has cleared the enable bit. The pointer register keeps the address where the walk stopped, so software can append work and ring the doorbell again.

The block has a word-addressed register port with combinational read data. It also has a single-beat memory master: a request is held, unchanged, until the memory acknowledges it.

Top module: `dchain_dma`

## Requirements
- R1: After reset the status register (offset 4) reads 0x1 (halted bit 0 set; doorbell bit 2 and valid bit 1 clear). The pending register (offset 3), the control register (offset 0) and the remaining-count register (offset 5) read 0. `irq` is low and `mem_req` is low.
- R2: A write of any value to offset 2 sets the doorbell bit (status bit 2). While control bit 0 (enable) is 0, the channel stays halted with the doorbell bit set and makes no memory access. Once enable is 1, a pending doorbell starts the walk at the descriptor pointer (offset 1), and the doorbell bit clears when the walk starts.
- R3: Descriptor word k is read from pointer + 4k. Bit 31 of word 0 is the valid bit. If that bit is 0, the channel halts right after the read: status reads 0x1 and the pointer still holds that descriptor's address.
- R4: For a valid descriptor, the byte count is the low 22 bits of word 1. The channel copies ceil(count/4) words. Each copy reads source + 4i (source from word 2) and then writes that word to destination + 4i (destination from word 4). A count of 0 copies nothing, and no word past the rounded count is written.
- R5: After the copy, bits 1:0 of word 0 choose what is written to pointer + 24: 0 writes nothing; 1 writes the channel status (0x2 when no doorbell is pending); 2 writes word 0 with bit 31 cleared; 3 writes the remaining byte count, which is 0.
- R6: When bit 2 of word 0 is set, the channel writes word 0 with bit 31 cleared back to pointer + 0. This write comes after the status write.
- R7: Every completed descriptor sets pending bit 0, whatever the value of word 0 bit 8. `irq` is high only while pending is set and bit 8 of the last completed descriptor was 1. Writing 1 to pending bit 0 clears it.
- R8: After a descriptor completes, the pointer becomes (word 7 bits 26:0) shifted left by 5, and the walk goes on from there. The pointer is always 32-byte aligned.
- R9: If enable is cleared during a walk, the current descriptor still completes. The channel then halts with the pointer at the next descriptor, which is left unprocessed.
- R10: Status bit 1 shows the valid bit of the descriptor most recently fetched. The remaining-count register reads 0 once a descriptor has completed.
- R11: While `mem_req` is high and `mem_ack` is low, the next cycle keeps `mem_req` high with `mem_addr`, `mem_we` and `mem_wdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| irq | output | 1 | Interrupt: pending and enabled by the last descriptor |

## Verification
The bench builds the block with AW = 12, so the byte address space is exactly the bench's 4 KB memory model and every stray access lands in memory the bench checks. BCW keeps its default of 22. Descriptors carry junk above bit 21 of the count word and above bit 26 of the next-pointer word, which tests that those fields are masked. Memory latency varies pseudo-randomly from access to access, so requests are held through waits of different lengths, and enable can be cleared while a long copy is in progress.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_RD    = 3'd2,
    ST_WR    = 3'd3,
    ST_STAT  = 3'd4,
    ST_CLRV  = 3'd5,
    ST_NEXT  = 3'd6
  } eng_state_t;

  // register word offsets
  localparam logic [2:0] RA_CTRL   = 3'd0;
  localparam logic [2:0] RA_DPTR   = 3'd1;
  localparam logic [2:0] RA_BELL   = 3'd2;
  localparam logic [2:0] RA_PEND   = 3'd3;
  localparam logic [2:0] RA_STAT   = 3'd4;
  localparam logic [2:0] RA_REMAIN = 3'd5;

  // descriptor layout and command-word fields
  localparam int VALID_BIT  = 31;
  localparam int IE_BIT     = 8;
  localparam int CV_BIT     = 2;
  localparam int NXT_W      = 27;
  localparam int ALIGN_W    = 5;
  localparam int STAT_OFS   = 24;

endpackage

// File: rtl/dchain_regs.sv
module dchain_regs
  import dchain_pkg::*;
#(
  parameter int AW  = 32,
  parameter int BCW = 22
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [2:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           halted,
  input  logic           desc_valid,
  input  logic [AW-1:0]  dptr,
  input  logic [BCW-1:0] remain,
  input  logic           start,
  input  logic           done,
  input  logic           done_ie,
  output logic           enable,
  output logic           bell_pend,
  output logic           dptr_wr,
  output logic           irq
);

  logic en_q, en_d;
  logic bell_q, bell_d;
  logic pend_q, pend_d;
  logic ie_q, ie_d;
  logic wr_ctrl, wr_bell, wr_pend;

  assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
  assign wr_bell = reg_we && (reg_addr == RA_BELL);
  assign wr_pend = reg_we && (reg_addr == RA_PEND);
  assign dptr_wr = reg_we && (reg_addr == RA_DPTR);

  always_comb begin
    en_d   = en_q;
    bell_d = bell_q;
    pend_d = pend_q;
    ie_d   = ie_q;
    if (wr_ctrl) en_d = reg_wdata[0];
    if (start)   bell_d = 1'b0;
    if (wr_bell) bell_d = 1'b1;
    if (wr_pend && reg_wdata[0]) pend_d = 1'b0;
    if (done) begin
      pend_d = 1'b1;
      ie_d   = done_ie;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      bell_q <= 1'b0;
      pend_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      en_q   <= en_d;
      bell_q <= bell_d;
      pend_q <= pend_d;
      ie_q   <= ie_d;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL:   reg_rdata = {31'b0, en_q};
      RA_DPTR:   reg_rdata = 32'(dptr);
      RA_PEND:   reg_rdata = {31'b0, pend_q};
      RA_STAT:   reg_rdata = {29'b0, bell_q, desc_valid, halted};
      RA_REMAIN: reg_rdata = 32'(remain);
      default:   reg_rdata = 32'b0;
    endcase
  end

  assign enable    = en_q;
  assign bell_pend = bell_q;
  assign irq       = pend_q & ie_q;

  // R7
  pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(done));

  // R2
  bell_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && en_q && bell_q) |=> !halted);

endmodule

// File: rtl/dchain_engine.sv
module dchain_engine
  import dchain_pkg::*;
#(
  parameter int AW  = 32,
  parameter int BCW = 22
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic           bell_pend,
  input  logic           dptr_wr,
  input  logic [AW-1:0]  dptr_wdata,
  output logic           start,
  output logic           done,
  output logic           done_ie,
  output logic           halted,
  output logic           desc_valid,
  output logic [AW-1:0]  dptr,
  output logic [BCW-1:0] remain,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic           mem_ack,
  input  logic [31:0]    mem_rdata
);

  localparam logic [AW-1:0]  WSTEP = AW'(4);
  localparam logic [BCW-1:0] BSTEP = BCW'(4);

  eng_state_t       state_q, state_d;
  logic [2:0]       widx_q, widx_d;
  logic [AW-1:0]    dptr_q, dptr_d;
  logic [31:0]      cmd0_q, cmd0_d;
  logic [BCW-1:0]   remain_q, remain_d;
  logic [AW-1:0]    src_q, src_d;
  logic [AW-1:0]    dst_q, dst_d;
  logic [NXT_W-1:0] nxt_q, nxt_d;
  logic [31:0]      data_q, data_d;
  logic             valid_q, valid_d;
  logic [31:0]      stat_word;
  logic [31:0]      cmd0_clr;
  logic             unused_lo;

  assign unused_lo = ^dptr_wdata[ALIGN_W-1:0];
  assign cmd0_clr  = {1'b0, cmd0_q[30:0]};

  always_comb begin
    case (cmd0_q[1:0])
      2'd1:    stat_word = {29'b0, bell_pend, valid_q, 1'b0};
      2'd2:    stat_word = cmd0_clr;
      2'd3:    stat_word = 32'(remain_q);
      default: stat_word = 32'b0;
    endcase
  end

  always_comb begin
    state_d   = state_q;
    widx_d    = widx_q;
    dptr_d    = dptr_q;
    cmd0_d    = cmd0_q;
    remain_d  = remain_q;
    src_d     = src_q;
    dst_d     = dst_q;
    nxt_d     = nxt_q;
    data_d    = data_q;
    valid_d   = valid_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = 32'b0;
    start     = 1'b0;
    done      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (dptr_wr) dptr_d = {dptr_wdata[AW-1:ALIGN_W], {ALIGN_W{1'b0}}};
        if (enable && bell_pend) begin
          start   = 1'b1;
          widx_d  = 3'd0;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = dptr_q + AW'({widx_q, 2'b00});
        if (mem_ack) begin
          widx_d = widx_q + 3'd1;
          case (widx_q)
            3'd0: begin
              cmd0_d  = mem_rdata;
              valid_d = mem_rdata[VALID_BIT];
              if (!mem_rdata[VALID_BIT]) state_d = ST_IDLE;
            end
            3'd1: remain_d = mem_rdata[BCW-1:0];
            3'd2: src_d    = mem_rdata[AW-1:0];
            3'd4: dst_d    = mem_rdata[AW-1:0];
            3'd7: begin
              nxt_d   = mem_rdata[NXT_W-1:0];
              state_d = ST_RD;
            end
            default: ;
          endcase
        end
      end
      ST_RD: begin
        if (remain_q == '0) begin
          data_d  = stat_word;
          state_d = ST_STAT;
        end else begin
          mem_req  = 1'b1;
          mem_addr = src_q;
          if (mem_ack) begin
            data_d  = mem_rdata;
            state_d = ST_WR;
          end
        end
      end
      ST_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dst_q;
        mem_wdata = data_q;
        if (mem_ack) begin
          src_d    = src_q + WSTEP;
          dst_d    = dst_q + WSTEP;
          remain_d = (remain_q > BSTEP) ? remain_q - BSTEP : '0;
          state_d  = ST_RD;
        end
      end
      ST_STAT: begin
        if (cmd0_q[1:0] == 2'd0) begin
          state_d = ST_CLRV;
        end else begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = dptr_q + AW'(STAT_OFS);
          mem_wdata = data_q;
          if (mem_ack) state_d = ST_CLRV;
        end
      end
      ST_CLRV: begin
        if (!cmd0_q[CV_BIT]) begin
          state_d = ST_NEXT;
        end else begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = dptr_q;
          mem_wdata = cmd0_clr;
          if (mem_ack) state_d = ST_NEXT;
        end
      end
      ST_NEXT: begin
        done    = 1'b1;
        dptr_d  = AW'({nxt_q, {ALIGN_W{1'b0}}});
        widx_d  = 3'd0;
        state_d = enable ? ST_FETCH : ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      widx_q   <= 3'd0;
      dptr_q   <= '0;
      cmd0_q   <= 32'b0;
      remain_q <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      nxt_q    <= '0;
      data_q   <= 32'b0;
      valid_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      widx_q   <= widx_d;
      dptr_q   <= dptr_d;
      cmd0_q   <= cmd0_d;
      remain_q <= remain_d;
      src_q    <= src_d;
      dst_q    <= dst_d;
      nxt_q    <= nxt_d;
      data_q   <= data_d;
      valid_q  <= valid_d;
    end
  end

  assign done_ie    = cmd0_q[IE_BIT];
  assign halted     = (state_q == ST_IDLE);
  assign desc_valid = valid_q;
  assign dptr       = dptr_q;
  assign remain     = remain_q;

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  // R4
  remain_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WR && mem_ack) |=> (remain_q < $past(remain_q)));

  // R3
  halt_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH && widx_q == 3'd0 && mem_ack && !mem_rdata[VALID_BIT])
      |=> (halted && !desc_valid && !mem_req));

  // R8
  dptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dptr_q[ALIGN_W-1:0] == '0);

endmodule

// File: rtl/dchain_dma.sv
module dchain_dma
  import dchain_pkg::*;
#(
  parameter int AW  = 32,
  parameter int BCW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          irq
);

  logic [1:0]     rsync_q;
  logic           rst_sn;
  logic           enable, bell_pend, dptr_wr;
  logic           start, done, done_ie, halted, desc_valid;
  logic [AW-1:0]  dptr;
  logic [BCW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  dchain_regs #(.AW(AW), .BCW(BCW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sn),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .halted     (halted),
    .desc_valid (desc_valid),
    .dptr       (dptr),
    .remain     (remain),
    .start      (start),
    .done       (done),
    .done_ie    (done_ie),
    .enable     (enable),
    .bell_pend  (bell_pend),
    .dptr_wr    (dptr_wr),
    .irq        (irq)
  );

  dchain_engine #(.AW(AW), .BCW(BCW)) u_engine (
    .clk        (clk),
    .rst_n      (rst_sn),
    .enable     (enable),
    .bell_pend  (bell_pend),
    .dptr_wr    (dptr_wr),
    .dptr_wdata (reg_wdata[AW-1:0]),
    .start      (start),
    .done       (done),
    .done_ie    (done_ie),
    .halted     (halted),
    .desc_valid (desc_valid),
    .dptr       (dptr),
    .remain     (remain),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata)
  );

endmodule

// File: tb/tb_dchain_dma.sv
`timescale 1ns/1ps
module tb_dchain_dma;

  localparam int AW = 12;
  localparam logic [2:0] A_CTRL = 3'd0, A_DPTR = 3'd1, A_BELL = 3'd2,
                         A_PEND = 3'd3, A_STAT = 3'd4, A_REM = 3'd5;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_we;
  logic [2:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic mem_req, mem_we, mem_ack, irq;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  dchain_dma #(.AW(AW), .BCW(22)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq)
  );

  // memory model with variable latency
  logic [31:0] mem [0:1023];
  logic [1:0]  wcnt;
  logic [7:0]  lfsr;
  int src_rd = 0, dst_wr = 0, hold_viol = 0;
  int nchk = 0, nfail = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_rdata <= 32'b0; wcnt <= 2'd0; lfsr <= 8'h5A;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (wcnt == 2'd0) begin
          mem_ack   <= 1'b1;
          mem_rdata <= mem[mem_addr[11:2]];
          if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
          if (!mem_we && mem_addr[11:10] == 2'b01) src_rd <= src_rd + 1;
          if (mem_we && mem_addr[11:10] == 2'b10) dst_wr <= dst_wr + 1;
          wcnt <= lfsr[1:0];
          lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end else begin
          wcnt <= wcnt - 2'd1;
        end
      end
    end
  end

  // R11 request hold monitor
  logic p_req, p_ack, p_we;
  logic [AW-1:0] p_addr;
  logic [31:0] p_wd;
  initial begin p_req = 1'b0; p_ack = 1'b0; p_we = 1'b0; p_addr = '0; p_wd = 32'b0; end
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_req && !p_ack &&
          (!mem_req || mem_addr != p_addr || mem_we != p_we || mem_wdata != p_wd))
        hold_viol = hold_viol + 1;
    end
    p_req = mem_req; p_ack = mem_ack; p_we = mem_we; p_addr = mem_addr; p_wd = mem_wdata;
  end

  typedef struct packed {
    logic [21:0] bc;
    logic [1:0]  st;
    logic        cv;
    logic        ie;
  } vec_t;
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{22'd16, 2'd1, 1'b0, 1'b1},
    '{22'd5,  2'd2, 1'b1, 1'b0},
    '{22'd0,  2'd3, 1'b0, 1'b1},
    '{22'd12, 2'd0, 1'b1, 1'b0},
    '{22'd4,  2'd2, 1'b0, 1'b1},
    '{22'd1,  2'd1, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    bit ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      reg_rd(A_STAT, s);
      if (s[0] && !s[2]) begin ok = 1'b1; break; end
    end
    if (!ok) begin nchk++; nfail++; $display("FAIL channel never halted"); end
  endtask

  function automatic logic [31:0] src_pat(input int v, input int i);
    return 32'hA500_0000 | (32'(v) << 8) | 32'(i);
  endfunction

  function automatic logic [31:0] mk_cmd0(input logic ie, input logic cv, input logic [1:0] st);
    return 32'hC000_0000 | (32'(ie) << 8) | (32'(cv) << 2) | 32'(st);
  endfunction

  task automatic fill(input int v);
    for (int i = 0; i < 32; i++)  mem[(12'h400 >> 2) + i] = src_pat(v, i);
    for (int i = 0; i < 128; i++) mem[(12'h800 >> 2) + i] = 32'h5EED_0000 | 32'(i);
  endtask

  task automatic put_desc(input int b, input logic [31:0] c0, input logic [21:0] bc,
                          input int src, input int dst, input int nxt);
    mem[b/4 + 0] = c0;
    mem[b/4 + 1] = 32'h0F00_0000 | 32'(bc);
    mem[b/4 + 2] = 32'(src);
    mem[b/4 + 3] = 32'h1234_5678;
    mem[b/4 + 4] = 32'(dst);
    mem[b/4 + 5] = 32'h8765_4321;
    mem[b/4 + 6] = 32'hDEAD_BEEF;
    mem[b/4 + 7] = 32'hF800_0000 | 32'(nxt >> 5);
  endtask

  // watchdog
  initial begin
    #(5.0 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] r, c0, exp_stat;
    vec_t vv;
    int nw, s0, d0;
    reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = 32'b0; rst_n = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    reg_rd(A_STAT, r); chk("R1 status", r, 32'h1);
    reg_rd(A_PEND, r); chk("R1 pending", r, 32'h0);
    reg_rd(A_CTRL, r); chk("R1 control", r, 32'h0);
    reg_rd(A_REM, r);  chk("R1 remaining", r, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 mem_req", {31'b0, mem_req}, 32'h0);

    // R2 doorbell while disabled, then enable
    fill(0);
    put_desc(12'h100, mk_cmd0(1'b0, 1'b0, 2'd0), 22'd8, 12'h400, 12'h800, 12'h200);
    mem[12'h200 >> 2] = 32'h0000_0123;
    d0 = dst_wr;
    reg_wr(A_DPTR, 32'h100);
    reg_wr(A_BELL, 32'h0);
    repeat (20) @(negedge clk);
    reg_rd(A_STAT, r); chk("R2 doorbell held while disabled", r, 32'h5);
    chk("R2 no copy while disabled", 32'(dst_wr - d0), 32'h0);
    reg_wr(A_CTRL, 32'h1);
    wait_idle();
    chk("R2 copy after enable w0", mem[12'h800 >> 2], src_pat(0, 0));
    chk("R2 copy after enable w1", mem[12'h804 >> 2], src_pat(0, 1));
    reg_rd(A_STAT, r); chk("R2 doorbell consumed", r, 32'h1);
    reg_wr(A_PEND, 32'h1);

    // table of single-descriptor vectors: R4 R5 R6 R7 R8 R10
    for (int k = 0; k < NV; k++) begin
      vv = VECS[k];
      fill(k + 1);
      c0 = mk_cmd0(vv.ie, vv.cv, vv.st);
      put_desc(12'h100, c0, vv.bc, 12'h400, 12'h800, 12'h200);
      mem[12'h200 >> 2] = 32'h0000_0000;
      s0 = src_rd; d0 = dst_wr;
      reg_wr(A_DPTR, 32'h100);
      reg_wr(A_BELL, 32'h0);
      wait_idle();
      nw = (int'(vv.bc) + 3) / 4;
      for (int i = 0; i < nw; i++)
        chk($sformatf("R4 vec%0d dest word %0d", k, i), mem[(12'h800 >> 2) + i], src_pat(k + 1, i));
      chk($sformatf("R4 vec%0d word past count untouched", k), mem[(12'h800 >> 2) + nw],
          32'h5EED_0000 | 32'(nw));
      chk($sformatf("R4 vec%0d source reads", k), 32'(src_rd - s0), 32'(nw));
      chk($sformatf("R4 vec%0d dest writes", k), 32'(dst_wr - d0), 32'(nw));
      case (vv.st)
        2'd0: exp_stat = 32'hDEAD_BEEF;
        2'd1: exp_stat = 32'h2;
        2'd2: exp_stat = c0 & 32'h7FFF_FFFF;
        default: exp_stat = 32'h0;
      endcase
      chk($sformatf("R5 vec%0d status word", k), mem[(12'h100 >> 2) + 6], exp_stat);
      chk($sformatf("R6 vec%0d command word", k), mem[12'h100 >> 2],
          vv.cv ? (c0 & 32'h7FFF_FFFF) : c0);
      reg_rd(A_PEND, r); chk($sformatf("R7 vec%0d pending", k), r, 32'h1);
      chk($sformatf("R7 vec%0d irq", k), {31'b0, irq}, {31'b0, vv.ie});
      reg_rd(A_DPTR, r); chk($sformatf("R8 vec%0d pointer", k), r, 32'h200);
      reg_rd(A_REM, r);  chk($sformatf("R10 vec%0d remaining", k), r, 32'h0);
      reg_rd(A_STAT, r); chk($sformatf("R3 vec%0d halted on invalid", k), r, 32'h1);
      reg_wr(A_PEND, 32'h1);
      reg_rd(A_PEND, r); chk($sformatf("R7 vec%0d pending cleared", k), r, 32'h0);
      chk($sformatf("R7 vec%0d irq cleared", k), {31'b0, irq}, 32'h0);
    end

    // R3 invalid first descriptor
    mem[12'h200 >> 2] = 32'h7FFF_FF07;
    s0 = src_rd;
    reg_wr(A_DPTR, 32'h200);
    reg_wr(A_BELL, 32'h0);
    wait_idle();
    reg_rd(A_DPTR, r); chk("R3 pointer kept", r, 32'h200);
    reg_rd(A_STAT, r); chk("R3 halted not valid", r, 32'h1);
    reg_rd(A_PEND, r); chk("R3 no completion", r, 32'h0);
    chk("R3 no source reads", 32'(src_rd - s0), 32'h0);
    mem[12'h200 >> 2] = 32'h0;

    // R8 two-descriptor chain
    fill(8);
    put_desc(12'h100, mk_cmd0(1'b0, 1'b1, 2'd0), 22'd8, 12'h400, 12'h800, 12'h140);
    put_desc(12'h140, mk_cmd0(1'b0, 1'b0, 2'd1), 22'd12, 12'h410, 12'h840, 12'h200);
    d0 = dst_wr;
    reg_wr(A_DPTR, 32'h100);
    reg_wr(A_BELL, 32'h0);
    wait_idle();
    chk("R8 second copy w0", mem[12'h840 >> 2], src_pat(8, 4));
    chk("R8 second copy w2", mem[12'h848 >> 2], src_pat(8, 6));
    chk("R8 second copy end", mem[12'h84C >> 2], 32'h5EED_0013);
    chk("R8 total dest writes", 32'(dst_wr - d0), 32'h5);
    chk("R6 first valid cleared", mem[12'h100 >> 2], mk_cmd0(1'b0, 1'b1, 2'd0) & 32'h7FFF_FFFF);
    chk("R5 second status word", mem[(12'h140 >> 2) + 6], 32'h2);
    reg_rd(A_DPTR, r); chk("R8 chain end pointer", r, 32'h200);
    reg_wr(A_PEND, 32'h1);

    // R9 enable cleared mid-walk
    fill(9);
    put_desc(12'h100, mk_cmd0(1'b0, 1'b0, 2'd0), 22'd128, 12'h400, 12'h800, 12'h140);
    put_desc(12'h140, mk_cmd0(1'b0, 1'b0, 2'd0), 22'd8, 12'h400, 12'h900, 12'h200);
    d0 = dst_wr;
    reg_wr(A_DPTR, 32'h100);
    reg_wr(A_BELL, 32'h0);
    repeat (60) @(negedge clk);
    reg_rd(A_STAT, r); chk("R10 running with valid descriptor", r, 32'h2);
    reg_wr(A_CTRL, 32'h0);
    wait_idle();
    reg_rd(A_DPTR, r); chk("R9 stopped at next descriptor", r, 32'h140);
    reg_rd(A_STAT, r); chk("R9 halted valid", r, 32'h3);
    chk("R9 current copy finished", mem[(12'h800 >> 2) + 31], src_pat(9, 31));
    chk("R9 next untouched", mem[12'h900 >> 2], 32'h5EED_0040);
    chk("R9 dest writes", 32'(dst_wr - d0), 32'd32);
    reg_rd(A_PEND, r); chk("R9 pending", r, 32'h1);

    // R11
    chk("R11 request hold violations", 32'(hold_viol), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule